// File: doc/BRIEF.md
# Hashed page table walker

This block resolves a translation miss by walking a hashed page table held in memory. A miss request carries the faulting effective address, a compare word, the base addresses of a primary and a secondary entry group, an access kind (instruction fetch, data load or data store), a privilege flag and two protection key bits. The walker reads 32-bit words through a single memory port that allows one access at a time. It compares the tag word of each entry with the compare word. If the primary group has no match, it tries the secondary group with a modified compare word.

On a match the walker fetches the second word of the entry and applies the access rules. Fetches to guarded pages are refused. Fetches and loads set the referenced bit. Stores either find the changed bit already set or pass a protection check before the referenced and changed bits are set. When a status bit has to be set in memory, the walker writes back the low halfword of the entry's second word. Each request ends with a one-cycle completion pulse. It carries either the word to load into a translation buffer or an encoded fault status.

Top module: `pt_walker`

## Requirements
- R1: `req_ready_o` is high only while the walker is idle. A request is taken on a cycle with `req_valid_i` and `req_ready_o` both high. Each request produces exactly one single-cycle `done_o` pulse with `hit_o`, `result_o` and `status_o`. `status_o` is zero on a hit, and `result_o` is zero on a fault. The idle state after reset has `done_o` and `mem_req_o` low.
- R2: The primary search reads the tag word at group base + 8*i for i = 0 to 7 in ascending order. It stops at the first entry whose tag equals the compare word. A hit at slot i therefore costs i+1 tag reads.
- R3: If no primary entry matches, the walk repeats over the secondary group with the compare word OR 0x40. If the secondary group also has no match, the request ends with hit 0 and status 0x40000000 for a fetch or a load, or 0x42000000 for a store, after 16 tag reads.
- R4: After a tag match the walker reads the second word at entry address + 4. A completed walk performs no reads beyond that one.
- R5: For a fetch (access code 2'b00), a matched second word with bit 3 (0x8) set ends with status 0x10000000 and no write. This check comes before the referenced bit handling.
- R6: For a fetch or a load (access code 2'b01), if bit 8 (0x100, referenced) of the second word is clear, the returned word has it set. The walker then writes one halfword, equal to the low 16 bits of the returned word, to entry address + 6. If the bit is already set, the word is returned unchanged and nothing is written.
- R7: For a store (access code 2'b10) whose second word has bit 7 (0x80, changed) set, the word is returned unchanged and nothing is written.
- R8: For a store with the changed bit clear and bits [1:0] equal to 2'b10, the walk hits. The returned word has 0x180 set, and its low halfword is written to entry address + 6 before `done_o`.
- R9: For a store with the changed bit clear and bits [1:0] equal to 2'b11, the walk ends with status 0x0A000000 and no write.
- R10: For a store with the changed bit clear and bits [1:0] equal to 2'b00 or 2'b01, a key is selected: `req_key_user_i` when `req_priv_i` is 1, otherwise `req_key_sup_i`. A selected key of 0 behaves as in R8. A selected key of 1 ends with status 0x0A000000 and no write.
- R11: `mem_req_o`, `mem_we_o` and `mem_addr_o` stay unchanged from the cycle an access is raised until the cycle in which `mem_rvalid_i` is seen. Any number of wait cycles is accepted. `mem_we_o` high marks a halfword write of `mem_wdata_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Miss request valid |
| req_ready_o | output | 1 | Walker idle, request can be taken |
| req_ea_i | input | 32 | Faulting effective address |
| req_cmp_i | input | 32 | Compare word for the tag search |
| req_grp0_i | input | 32 | Primary group base address |
| req_grp1_i | input | 32 | Secondary group base address |
| req_acc_i | input | 2 | Access kind: 00 fetch, 01 load, 10 store |
| req_priv_i | input | 1 | Privilege flag that selects the key |
| req_key_user_i | input | 1 | Key used when the privilege flag is 1 |
| req_key_sup_i | input | 1 | Key used when the privilege flag is 0 |
| mem_req_o | output | 1 | Memory access pending |
| mem_we_o | output | 1 | Access is a halfword write |
| mem_addr_o | output | 32 | Byte address of the access |
| mem_wdata_o | output | 16 | Halfword write data |
| mem_rvalid_i | input | 1 | Access acknowledged, read data valid |
| mem_rdata_i | input | 32 | Read data |
| done_o | output | 1 | One-cycle completion pulse |
| hit_o | output | 1 | Entry found and access allowed |
| result_o | output | 32 | Word for the translation buffer |
| status_o | output | 32 | Fault code, zero on a hit |
| res_ea_o | output | 32 | Effective address of the completed request |

## Verification
The completion pulse of one walk and the acceptance of the next request fall in the same cycle, because the walker returns to idle as it reports. The bench holds requests back to back. `req_valid_i` for the next miss is already high when `done_o` rises, so the handover edge also starts the next tag read. A scoreboard matches each completion, in order, against an expected item. Each item records hit, word, status, the exact number of reads and the single write address and data. A result that belongs to the wrong request, or a read that leaks across the boundary, therefore shows up as a mismatch. Memory latency cycles through zero, one and two wait cycles, so the boundary lands on different access phases.

// File: rtl/pt_walk_pkg.sv
package pt_walk_pkg;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'b00,
    ACC_LOAD  = 2'b01,
    ACC_STORE = 2'b10
  } acc_e;

  typedef enum logic [1:0] {
    V_HIT,
    V_NEED_WB,
    V_FAULT
  } verdict_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_TAG,
    ST_PTE,
    ST_WB
  } walk_state_e;

  localparam int BIT_GUARD = 3;
  localparam int BIT_CHG   = 7;
  localparam int BIT_REF   = 8;

  localparam logic [31:0] STAT_GUARD    = 32'h1000_0000;
  localparam logic [31:0] STAT_NF       = 32'h4000_0000;
  localparam logic [31:0] STAT_NF_STORE = 32'h4200_0000;
  localparam logic [31:0] STAT_PROT     = 32'h0A00_0000;

endpackage

// File: rtl/pt_walk_addr.sv
module pt_walk_addr #(
  parameter int AW          = 32,
  parameter int ENTRIES     = 8,
  parameter int ENTRY_BYTES = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] base_i,
  input  logic          step_i,
  output logic [AW-1:0] entry_o,
  output logic          last_o
);
  localparam int IW    = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int SHIFT = $clog2(ENTRY_BYTES);

  logic [AW-1:0] base_q;
  logic [IW-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      idx_q  <= '0;
    end else if (load_i) begin
      base_q <= base_i;
      idx_q  <= '0;
    end else if (step_i) begin
      idx_q  <= idx_q + 1'b1;
    end
  end

  assign entry_o = base_q + AW'({idx_q, {SHIFT{1'b0}}});
  assign last_o  = (idx_q == IW'(ENTRIES - 1));

  // stepping past the final slot would wrap into a foreign group
  AST_STEP_IN_GROUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |-> !last_o); // R2

endmodule

// File: rtl/pt_walk_decide.sv
module pt_walk_decide
  import pt_walk_pkg::*;
#(
  parameter int DW = 32
) (
  input  acc_e              acc_i,
  input  logic [DW-1:0]     pte_i,
  input  logic              key_i,
  output verdict_e          verdict_o,
  output logic [DW-1:0]     word_o,
  output logic [31:0]       status_o
);
  localparam logic [DW-1:0] REF_M = DW'(1) << BIT_REF;
  localparam logic [DW-1:0] CHG_M = DW'(1) << BIT_CHG;

  always_comb begin
    verdict_o = V_HIT;
    word_o    = pte_i;
    status_o  = '0;
    if (acc_i == ACC_STORE) begin
      if (!pte_i[BIT_CHG]) begin
        unique case (pte_i[1:0])
          2'b10: begin
            verdict_o = V_NEED_WB;
            word_o    = pte_i | REF_M | CHG_M;
          end
          2'b11: begin
            verdict_o = V_FAULT;
            status_o  = STAT_PROT;
          end
          default: begin
            if (key_i) begin
              verdict_o = V_FAULT;
              status_o  = STAT_PROT;
            end else begin
              verdict_o = V_NEED_WB;
              word_o    = pte_i | REF_M | CHG_M;
            end
          end
        endcase
      end
    end else if (acc_i == ACC_FETCH && pte_i[BIT_GUARD]) begin
      verdict_o = V_FAULT;
      status_o  = STAT_GUARD;
    end else if (!pte_i[BIT_REF]) begin
      verdict_o = V_NEED_WB;
      word_o    = pte_i | REF_M;
    end
    if (verdict_o == V_FAULT) word_o = '0;
  end

endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walk_pkg::*;
#(
  parameter int AW          = 32,
  parameter int DW          = 32,
  parameter int ENTRIES     = 8,
  parameter int ENTRY_BYTES = 8,
  parameter int SEC_BIT     = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_valid_i,
  output logic            req_ready_o,
  input  logic [AW-1:0]   req_ea_i,
  input  logic [DW-1:0]   req_cmp_i,
  input  logic [AW-1:0]   req_grp0_i,
  input  logic [AW-1:0]   req_grp1_i,
  input  logic [1:0]      req_acc_i,
  input  logic            req_priv_i,
  input  logic            req_key_user_i,
  input  logic            req_key_sup_i,
  output logic            mem_req_o,
  output logic            mem_we_o,
  output logic [AW-1:0]   mem_addr_o,
  output logic [DW/2-1:0] mem_wdata_o,
  input  logic            mem_rvalid_i,
  input  logic [DW-1:0]   mem_rdata_i,
  output logic            done_o,
  output logic            hit_o,
  output logic [DW-1:0]   result_o,
  output logic [31:0]     status_o,
  output logic [AW-1:0]   res_ea_o
);
  localparam int HW              = DW / 2;
  localparam logic [DW-1:0] SEC_M = DW'(1) << SEC_BIT;
  localparam logic [AW-1:0] OFF_W1 = AW'(ENTRY_BYTES / 2);
  localparam logic [AW-1:0] OFF_HW = AW'(ENTRY_BYTES - 2);

  walk_state_e state_q, state_d;
  acc_e        acc_q;
  logic        key_q, pass_q;
  logic [DW-1:0] cmp_q, word_q;
  logic [AW-1:0] grp1_q, ea_q;

  logic          load_base, step, last;
  logic [AW-1:0] base_sel, entry;

  verdict_e      dec_verdict;
  logic [DW-1:0] dec_word;
  logic [31:0]   dec_stat;

  logic          finish, fin_hit;
  logic [DW-1:0] fin_res;
  logic [31:0]   fin_stat;

  logic          done_q, hit_q;
  logic [DW-1:0] result_q;
  logic [31:0]   status_q;

  assign base_sel = (state_q == ST_IDLE) ? req_grp0_i : grp1_q;

  pt_walk_addr #(
    .AW(AW), .ENTRIES(ENTRIES), .ENTRY_BYTES(ENTRY_BYTES)
  ) u_addr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_base),
    .base_i (base_sel),
    .step_i (step),
    .entry_o(entry),
    .last_o (last)
  );

  pt_walk_decide #(.DW(DW)) u_decide (
    .acc_i    (acc_q),
    .pte_i    (mem_rdata_i),
    .key_i    (key_q),
    .verdict_o(dec_verdict),
    .word_o   (dec_word),
    .status_o (dec_stat)
  );

  always_comb begin
    state_d   = state_q;
    load_base = 1'b0;
    step      = 1'b0;
    finish    = 1'b0;
    fin_hit   = 1'b0;
    fin_res   = '0;
    fin_stat  = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid_i) begin
          load_base = 1'b1;
          state_d   = ST_TAG;
        end
      end
      ST_TAG: begin
        if (mem_rvalid_i) begin
          if (mem_rdata_i == cmp_q) begin
            state_d = ST_PTE;
          end else if (!last) begin
            step = 1'b1;
          end else if (!pass_q) begin
            load_base = 1'b1;
          end else begin
            finish   = 1'b1;
            fin_stat = (acc_q == ACC_STORE) ? STAT_NF_STORE : STAT_NF;
            state_d  = ST_IDLE;
          end
        end
      end
      ST_PTE: begin
        if (mem_rvalid_i) begin
          unique case (dec_verdict)
            V_NEED_WB: state_d = ST_WB;
            V_FAULT: begin
              finish   = 1'b1;
              fin_stat = dec_stat;
              state_d  = ST_IDLE;
            end
            default: begin
              finish  = 1'b1;
              fin_hit = 1'b1;
              fin_res = dec_word;
              state_d = ST_IDLE;
            end
          endcase
        end
      end
      ST_WB: begin
        if (mem_rvalid_i) begin
          finish  = 1'b1;
          fin_hit = 1'b1;
          fin_res = word_q;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      acc_q    <= ACC_FETCH;
      key_q    <= 1'b0;
      pass_q   <= 1'b0;
      cmp_q    <= '0;
      word_q   <= '0;
      grp1_q   <= '0;
      ea_q     <= '0;
      done_q   <= 1'b0;
      hit_q    <= 1'b0;
      result_q <= '0;
      status_q <= '0;
    end else begin
      state_q <= state_d;
      done_q  <= finish;
      if (state_q == ST_IDLE && req_valid_i) begin
        acc_q  <= acc_e'(req_acc_i);
        key_q  <= req_priv_i ? req_key_user_i : req_key_sup_i;
        pass_q <= 1'b0;
        cmp_q  <= req_cmp_i;
        grp1_q <= req_grp1_i;
        ea_q   <= req_ea_i;
      end else if (state_q == ST_TAG && load_base) begin
        pass_q <= 1'b1;
        cmp_q  <= cmp_q | SEC_M;
      end
      if (state_q == ST_PTE && mem_rvalid_i) word_q <= dec_word;
      if (finish) begin
        hit_q    <= fin_hit;
        result_q <= fin_res;
        status_q <= fin_stat;
      end
    end
  end

  always_comb begin
    unique case (state_q)
      ST_PTE:  mem_addr_o = entry + OFF_W1;
      ST_WB:   mem_addr_o = entry + OFF_HW;
      default: mem_addr_o = entry;
    endcase
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign mem_req_o   = (state_q != ST_IDLE);
  assign mem_we_o    = (state_q == ST_WB);
  assign mem_wdata_o = word_q[HW-1:0];
  assign done_o      = done_q;
  assign hit_o       = hit_q;
  assign result_o    = result_q;
  assign status_o    = status_q;
  assign res_ea_o    = ea_q;

  AST_MEM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_rvalid_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)); // R11
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R1
  AST_HIT_NO_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && hit_o |-> status_o == '0); // R1
  AST_FAULT_CODED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !hit_o |-> status_o != '0 && result_o == '0); // R1
  AST_IDLE_NO_MEM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !mem_req_o); // R1
  AST_WB_HAS_REF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> mem_wdata_o[BIT_REF]); // R6
  AST_STORE_HIT_DIRTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && hit_o && acc_q == ACC_STORE |-> result_o[BIT_CHG]); // R8

endmodule

// File: tb/pt_walker_tb.sv
module pt_walker_tb;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [31:0] req_ea_i = '0, req_cmp_i = '0, req_grp0_i = '0, req_grp1_i = '0;
  logic [1:0]  req_acc_i = '0;
  logic        req_priv_i = 1'b0, req_key_user_i = 1'b0, req_key_sup_i = 1'b0;
  logic        mem_req_o, mem_we_o;
  logic [31:0] mem_addr_o;
  logic [15:0] mem_wdata_o;
  logic        mem_rvalid_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;
  logic        done_o, hit_o;
  logic [31:0] result_o, status_o, res_ea_o;

  always #4 clk_i = ~clk_i;

  pt_walker u_dut (.*);

  typedef struct {
    logic        hit;
    logic [31:0] res;
    logic [31:0] stat;
    logic        wr;
    logic [31:0] wr_addr;
    logic [15:0] wr_data;
    int          rd;
    logic [31:0] ea;
    string       tag;
  } exp_t;

  exp_t        sb_q[$];
  logic [31:0] mem [logic [31:0]];
  int n_chk = 0, n_err = 0;
  int rd_n = 0, wr_n = 0, resp_n = 0, wait_c = 0, stab_err = 0;
  logic [31:0] wr_a = '0;
  logic [15:0] wr_d = '0;
  logic        pend = 1'b0, pend_we = 1'b0;
  logic [31:0] pend_addr = '0;

  task automatic chk(input string r, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", r, what, act, exp);
    end
  endtask

  // monitor first, then memory model, in one process to fix ordering
  always @(negedge clk_i) begin
    if (rst_ni && done_o) begin
      if (sb_q.size() == 0) begin
        chk("R1", "unexpected done", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        chk(e.tag, "hit", 32'(hit_o), 32'(e.hit));
        chk(e.tag, "result", result_o, e.res);
        chk(e.tag, "status", status_o, e.stat);
        chk(e.tag, "reads", 32'(rd_n), 32'(e.rd));
        chk(e.tag, "writes", 32'(wr_n), e.wr ? 32'd1 : 32'd0);
        chk(e.tag, "ea", res_ea_o, e.ea);
        if (e.wr) begin
          chk(e.tag, "wr addr", wr_a, e.wr_addr);
          chk(e.tag, "wr data", 32'(wr_d), 32'(e.wr_data));
        end
      end
      rd_n = 0;
      wr_n = 0;
    end
    mem_rvalid_i = 1'b0;
    if (pend && (!mem_req_o || mem_addr_o != pend_addr || mem_we_o != pend_we)) stab_err++;
    pend = 1'b0;
    if (rst_ni && mem_req_o) begin
      if (wait_c >= resp_n % 3) begin
        mem_rvalid_i = 1'b1;
        wait_c = 0;
        resp_n++;
        if (mem_we_o) begin
          wr_n++;
          wr_a = mem_addr_o;
          wr_d = mem_wdata_o;
          mem_rdata_i = '0;
        end else begin
          rd_n++;
          mem_rdata_i = mem.exists(mem_addr_o) ? mem[mem_addr_o] : 32'hDEAD_BEEF;
        end
      end else begin
        wait_c++;
        pend = 1'b1;
        pend_addr = mem_addr_o;
        pend_we = mem_we_o;
      end
    end
  end

  // driver: lays out two groups, pushes the expectation, hands over the request
  task automatic run(input int id, input logic [1:0] acc, input logic priv, input logic ku,
                     input logic ks, input logic [31:0] cmp, input int slot, input int pass,
                     input logic [31:0] pte, input logic e_hit, input logic [31:0] e_res,
                     input logic [31:0] e_stat, input logic e_wr, input int e_rd, input string tag);
    logic [31:0] b0, b1, ent;
    exp_t e;
    bit took;
    b0 = 32'h0001_0000 + 32'(id) * 32'h1000;
    b1 = b0 + 32'h800;
    ent = '0;
    for (int i = 0; i < 8; i++) begin
      mem[b0 + 32'(8*i)]     = 32'h0BAD_0000 | (32'(id) << 8) | 32'(i);
      mem[b0 + 32'(8*i) + 4] = 32'h0;
      mem[b1 + 32'(8*i)]     = 32'h0BAD_0080 | (32'(id) << 8) | 32'(i);
      mem[b1 + 32'(8*i) + 4] = 32'h0;
    end
    if (slot >= 0) begin
      ent = (pass != 0 ? b1 : b0) + 32'(8*slot);
      mem[ent]     = (pass != 0) ? (cmp | 32'h40) : cmp;
      mem[ent + 4] = pte;
    end else if (slot == -2) begin
      mem[b1] = cmp;
    end
    e.hit = e_hit; e.res = e_res; e.stat = e_stat; e.wr = e_wr;
    e.wr_addr = ent + 6; e.wr_data = e_res[15:0]; e.rd = e_rd;
    e.ea = 32'hE000_0000 | 32'(id); e.tag = tag;
    sb_q.push_back(e);
    req_valid_i = 1'b1;
    req_ea_i = e.ea; req_cmp_i = cmp; req_grp0_i = b0; req_grp1_i = b1;
    req_acc_i = acc; req_priv_i = priv; req_key_user_i = ku; req_key_sup_i = ks;
    took = 1'b0;
    while (!took) begin
      took = req_ready_o;
      @(posedge clk_i);
      @(negedge clk_i);
    end
    req_valid_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1", "reset ready", 32'(req_ready_o), 32'd1);
    chk("R1", "reset done", 32'(done_o), 32'd0);
    chk("R1", "reset mem_req", 32'(mem_req_o), 32'd0);
    // fetch, slot 0, ref already set
    run(1, 2'b00, 0, 0, 0, 32'h8000_0011, 0, 0, 32'h0000_1102, 1, 32'h0000_1102, 0, 0, 2, "R2");
    // load, slot 5, ref clear
    run(2, 2'b01, 0, 0, 0, 32'h8000_0022, 5, 0, 32'h0000_2002, 1, 32'h0000_2102, 0, 1, 7, "R6");
    // fetch, secondary slot 3
    run(3, 2'b00, 0, 0, 0, 32'h8000_0033, 3, 1, 32'h0000_3100, 1, 32'h0000_3100, 0, 0, 13, "R3");
    // fetch to guarded page with ref clear
    run(4, 2'b00, 0, 0, 0, 32'h8000_0004, 2, 0, 32'h0000_0008, 0, 0, 32'h1000_0000, 0, 4, "R5");
    // not found; raw compare placed in secondary must not match
    run(5, 2'b00, 0, 0, 0, 32'h8000_0005, -2, 0, 0, 0, 0, 32'h4000_0000, 0, 16, "R3");
    run(6, 2'b01, 0, 0, 0, 32'h8000_0006, -1, 0, 0, 0, 0, 32'h4000_0000, 0, 16, "R3");
    run(7, 2'b10, 0, 0, 0, 32'h8000_0007, -1, 0, 0, 0, 0, 32'h4200_0000, 0, 16, "R3");
    // store, changed already set
    run(8, 2'b10, 0, 0, 0, 32'h8000_0008, 7, 0, 32'h0000_4182, 1, 32'h0000_4182, 0, 0, 9, "R7");
    // load, secondary slot 7, ref clear
    run(9, 2'b01, 0, 0, 0, 32'h8000_0009, 7, 1, 32'h0001_5000, 1, 32'h0001_5100, 0, 1, 17, "R4");
    run(10, 2'b10, 0, 0, 0, 32'h8000_000A, 1, 0, 32'h0000_5002, 1, 32'h0000_5182, 0, 1, 3, "R8");
    run(11, 2'b10, 0, 0, 0, 32'h8000_000B, 1, 0, 32'h0000_5003, 0, 0, 32'h0A00_0000, 0, 3, "R9");
    run(12, 2'b10, 1, 0, 1, 32'h8000_000C, 4, 0, 32'h0000_6001, 1, 32'h0000_6181, 0, 1, 6, "R10");
    run(13, 2'b10, 1, 1, 0, 32'h8000_000D, 4, 0, 32'h0000_6000, 0, 0, 32'h0A00_0000, 0, 6, "R10");
    run(14, 2'b10, 0, 1, 0, 32'h8000_000E, 0, 1, 32'h0000_6000, 1, 32'h0000_6180, 0, 1, 10, "R10");
    run(15, 2'b10, 0, 0, 1, 32'h8000_000F, 0, 0, 32'h0000_6001, 0, 0, 32'h0A00_0000, 0, 2, "R10");
    // store with pp=10 but key set: key must not matter
    run(16, 2'b10, 1, 1, 1, 32'h8000_0010, 6, 0, 32'h0000_7002, 1, 32'h0000_7182, 0, 1, 8, "R8");
    while (sb_q.size() != 0) @(negedge clk_i);
    repeat (4) @(negedge clk_i);
    chk("R11", "held access changed", 32'(stab_err), 32'd0);
    chk("R1", "pending items", 32'(sb_q.size()), 32'd0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++;
    n_err++;
    $display("FAIL R1 watchdog: actual=hung expected=complete");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule